// File: doc/BRIEF.md
# Sliced Ternary Rule Matcher

This block sorts packets in two lookups against one small ternary table. In the first lookup, a header key that has already been extracted is compared against the mapping rules, and the virtual instance that owns the packet comes back. In the second lookup, the same key and that instance number are compared against the action rules, and the index of the winning rule comes back. Software uses that index to fetch the action to apply. Every rule holds a value, a care mask and a small result field. A bit whose mask is 0 matches anything.

The table is cut into fixed-size slices. Each slice carries three things: a used flag, a region (mapping or action) and an owning instance. A lookup switches on only the slices that belong to the region being searched. For an action lookup, a slice must also belong to the instance making the request, so one tenant can never hit another tenant's rules. Within the enabled slices, the lowest matching address wins.

If no mapping rule matches, the packet goes to a fixed default instance that is handled in software. An instance can place an all-don't-care rule at the end of its action slices to act as its own fallback. It can move itself to software by overwriting its first rule with that catch-all.

A single configuration port writes either one entry or one slice record. Each write is acknowledged one cycle later. Lookups are fully pipelined, take two cycles and can be issued every cycle.

Top module: `sliced_rule_matcher`

## Requirements
- R1: An entry matches a lookup word when, for every bit whose care mask is 1, the stored value bit equals the word bit. Bits whose mask is 0 are ignored.
- R2: When several enabled entries match, the result reports the lowest entry address. The index is {slice number, position in slice}.
- R3: An action lookup (lk_region=1) compares only slices that are marked used, are tagged as action slices and are owned by lk_inst.
- R4: A mapping lookup (lk_region=0) compares only slices that are marked used and tagged as mapping slices, whatever their owner.
- R5: The lookup word is {instance field, key}, with the instance field in the upper ID_W bits. An action lookup puts lk_inst in that field, and a mapping lookup puts zero there.
- R6: On a miss, rs_hit=0 and rs_index=0. rs_data is DEF_INST for a mapping lookup and 0 for an action lookup. On a hit, rs_data is the result field stored in the winning entry.
- R7: rs_valid goes high exactly two rising edges after a cycle with lk_req=1, once for each request. Requests may arrive back to back.
- R8: cfg_ack goes high in the cycle after a cycle with cfg_we=1. A lookup issued in the same cycle as a write sees the old contents. A lookup issued from the acknowledge cycle onward sees the new contents.
- R9: After reset, every slice is unused, every entry is invalid and cfg_ack and rs_valid are 0, so every lookup misses.
- R10: An entry written with cfg_flag=0 never matches, even when its mask is all zero.
- R11: Overwriting an instance's first action entry with an all-don't-care rule makes every action lookup for that instance hit that entry.
- R12: Writing a slice record with cfg_flag=0 removes all of that slice's entries from later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 writes one entry, 1 writes the record of the slice that contains cfg_addr |
| cfg_addr | input | 6 | Entry address; its upper bits select the slice |
| cfg_value | input | 72 | Entry value, {instance field, key} |
| cfg_mask | input | 72 | Entry care mask, 1 means compare |
| cfg_data | input | 8 | Entry result field, or slice owner for a slice write |
| cfg_flag | input | 1 | Entry valid, or slice used |
| cfg_region | input | 1 | Slice region for a slice write: 0 mapping, 1 action |
| cfg_ack | output | 1 | Write acknowledge, one cycle after cfg_we |
| lk_req | input | 1 | Lookup request |
| lk_region | input | 1 | 0 mapping lookup, 1 action lookup |
| lk_inst | input | 8 | Requesting instance for an action lookup |
| lk_key | input | 64 | Extracted header key |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | A rule matched |
| rs_index | output | 6 | Winning entry address |
| rs_data | output | 8 | Result field of the winner, or the miss default |

## Verification
The assertions assume that lk_req and cfg_we are never X once reset is released, and that the configuration fields are stable whenever cfg_we is high. The bench drives every input at the falling edge, holds it for a whole cycle and idles all strobes low between scenarios. The enable check expects slice records to change only through the configuration port. The bench therefore writes every slice record before it issues lookups that depend on it. The one exception is the in-flight case, where a write and a lookup deliberately share a cycle.

// File: rtl/trm_pkg.sv
package trm_pkg;

  typedef enum logic {
    RGN_MAP = 1'b0,
    RGN_ACT = 1'b1
  } rgn_e;

  typedef enum logic {
    CFG_ENTRY = 1'b0,
    CFG_SLICE = 1'b1
  } cfg_e;

endpackage

// File: rtl/trm_slice.sv
module trm_slice #(
  parameter int SLICE_SZ = 8,
  parameter int WORD_W   = 72,
  parameter int DATA_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(SLICE_SZ)-1:0] wr_addr,
  input  logic [WORD_W-1:0]           wr_value,
  input  logic [WORD_W-1:0]           wr_mask,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        wr_valid,
  input  logic                        en_i,
  input  logic [WORD_W-1:0]           word_i,
  output logic                        hit_o,
  output logic [$clog2(SLICE_SZ)-1:0] lidx_o,
  output logic [DATA_W-1:0]           data_o
);
  localparam int LW = $clog2(SLICE_SZ);

  // R1: ternary compare, a mask bit of 1 means "must equal"
  function automatic logic tern_hit(input logic [WORD_W-1:0] v,
                                    input logic [WORD_W-1:0] m,
                                    input logic [WORD_W-1:0] w);
    return ((v ^ w) & m) == '0;
  endfunction

  logic [WORD_W-1:0] ent_val [SLICE_SZ];
  logic [WORD_W-1:0] ent_msk [SLICE_SZ];
  logic [DATA_W-1:0] ent_dat [SLICE_SZ];
  logic [SLICE_SZ-1:0] ent_vld;
  logic [SLICE_SZ-1:0] hit_vec;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_val[wr_addr] <= wr_value;
      ent_msk[wr_addr] <= wr_mask;
      ent_dat[wr_addr] <= wr_data;
    end
  end

  // R9, R10: valid bits cleared on reset, invalid entries never match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ent_vld <= '0;
    else if (wr_en) ent_vld[wr_addr] <= wr_valid;
  end

  for (genvar g = 0; g < SLICE_SZ; g++) begin : g_cmp
    assign hit_vec[g] = en_i && ent_vld[g] && tern_hit(ent_val[g], ent_msk[g], word_i);
  end

  // R2: lowest local position wins
  always_comb begin
    hit_o  = |hit_vec;
    lidx_o = '0;
    data_o = '0;
    for (int i = SLICE_SZ - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        lidx_o = LW'(i);
        data_o = ent_dat[i];
      end
    end
  end

endmodule

// File: rtl/trm_slice_dir.sv
module trm_slice_dir
  import trm_pkg::*;
#(
  parameter int NSLICE = 8,
  parameter int ID_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(NSLICE)-1:0] wr_slice,
  input  logic                      wr_used,
  input  logic                      wr_region,
  input  logic [ID_W-1:0]           wr_owner,
  input  logic                      lk_region,
  input  logic [ID_W-1:0]           lk_inst,
  output logic [NSLICE-1:0]         en_o
);
  logic [NSLICE-1:0] sl_used;
  logic [NSLICE-1:0] sl_rgn;
  logic [ID_W-1:0]   sl_owner [NSLICE];

  // R9, R12: used flags cleared on reset and by a release write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_used <= '0;
      sl_rgn  <= '0;
    end else if (wr_en) begin
      sl_used[wr_slice] <= wr_used;
      sl_rgn[wr_slice]  <= wr_region;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) sl_owner[wr_slice] <= wr_owner;
  end

  // R3, R4: region always checked, owner only for action lookups
  for (genvar s = 0; s < NSLICE; s++) begin : g_en
    assign en_o[s] = sl_used[s] && (sl_rgn[s] == lk_region) &&
                     ((rgn_e'(lk_region) == RGN_MAP) || (sl_owner[s] == lk_inst));
  end

endmodule

// File: rtl/trm_resolve.sv
module trm_resolve
  import trm_pkg::*;
#(
  parameter int NSLICE   = 8,
  parameter int LW       = 3,
  parameter int DATA_W   = 8,
  parameter logic [DATA_W-1:0] DEF_INST = '1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             a_vld,
  input  logic                             a_region,
  input  logic [NSLICE-1:0]                a_hit,
  input  logic [NSLICE-1:0][LW-1:0]        a_lidx,
  input  logic [NSLICE-1:0][DATA_W-1:0]    a_data,
  output logic                             rs_valid,
  output logic                             rs_hit,
  output logic [$clog2(NSLICE)+LW-1:0]     rs_index,
  output logic [DATA_W-1:0]                rs_data
);
  localparam int SW = $clog2(NSLICE);

  logic [SW+LW-1:0] win_idx;
  logic [DATA_W-1:0] win_data;
  logic              any_hit;
  logic              rs_region;

  // R2: lowest slice with a hit wins across slices
  always_comb begin
    any_hit  = |a_hit;
    win_idx  = '0;
    win_data = (rgn_e'(a_region) == RGN_MAP) ? DEF_INST : '0;  // R6
    for (int s = NSLICE - 1; s >= 0; s--) begin
      if (a_hit[s]) begin
        win_idx  = {SW'(s), a_lidx[s]};
        win_data = a_data[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_hit    <= 1'b0;
      rs_index  <= '0;
      rs_data   <= '0;
      rs_region <= 1'b0;
    end else begin
      rs_valid <= a_vld;
      if (a_vld) begin
        rs_hit    <= any_hit;
        rs_index  <= win_idx;
        rs_data   <= win_data;
        rs_region <= a_region;
      end
    end
  end

  p_map_miss_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit && rgn_e'(rs_region) == RGN_MAP) |-> (rs_data == DEF_INST));

  p_miss_index_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_index == '0));

endmodule

// File: rtl/sliced_rule_matcher.sv
module sliced_rule_matcher
  import trm_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int KEY_W    = 64,
  parameter int SLICE_SZ = 8,
  parameter int ID_W     = 8,
  parameter logic [ID_W-1:0] DEF_INST = 8'hFE
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic                        cfg_kind,
  input  logic [$clog2(ENTRIES)-1:0]  cfg_addr,
  input  logic [KEY_W+ID_W-1:0]       cfg_value,
  input  logic [KEY_W+ID_W-1:0]       cfg_mask,
  input  logic [ID_W-1:0]             cfg_data,
  input  logic                        cfg_flag,
  input  logic                        cfg_region,
  output logic                        cfg_ack,
  input  logic                        lk_req,
  input  logic                        lk_region,
  input  logic [ID_W-1:0]             lk_inst,
  input  logic [KEY_W-1:0]            lk_key,
  output logic                        rs_valid,
  output logic                        rs_hit,
  output logic [$clog2(ENTRIES)-1:0]  rs_index,
  output logic [ID_W-1:0]             rs_data
);
  localparam int NSLICE = ENTRIES / SLICE_SZ;
  localparam int LW     = $clog2(SLICE_SZ);
  localparam int SW     = $clog2(NSLICE);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int WORD_W = KEY_W + ID_W;

  // R5: instance field sits above the key, zero for mapping lookups
  logic [WORD_W-1:0] lk_word;
  assign lk_word = {(rgn_e'(lk_region) == RGN_ACT) ? lk_inst : '0, lk_key};

  logic [SW-1:0] cfg_slice;
  logic          ent_we;
  logic          dir_we;
  assign cfg_slice = cfg_addr[IDX_W-1:LW];
  assign ent_we    = cfg_we && (cfg_e'(cfg_kind) == CFG_ENTRY);
  assign dir_we    = cfg_we && (cfg_e'(cfg_kind) == CFG_SLICE);

  logic [NSLICE-1:0]              sl_en;
  logic [NSLICE-1:0]              sl_hit;
  logic [NSLICE-1:0][LW-1:0]      sl_lidx;
  logic [NSLICE-1:0][ID_W-1:0]    sl_data;

  trm_slice_dir #(.NSLICE(NSLICE), .ID_W(ID_W)) u_dir (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (dir_we),
    .wr_slice  (cfg_slice),
    .wr_used   (cfg_flag),
    .wr_region (cfg_region),
    .wr_owner  (cfg_data),
    .lk_region (lk_region),
    .lk_inst   (lk_inst),
    .en_o      (sl_en)
  );

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    trm_slice #(.SLICE_SZ(SLICE_SZ), .WORD_W(WORD_W), .DATA_W(ID_W)) u_sl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ent_we && (cfg_slice == SW'(s))),
      .wr_addr  (cfg_addr[LW-1:0]),
      .wr_value (cfg_value),
      .wr_mask  (cfg_mask),
      .wr_data  (cfg_data),
      .wr_valid (cfg_flag),
      .en_i     (sl_en[s]),
      .word_i   (lk_word),
      .hit_o    (sl_hit[s]),
      .lidx_o   (sl_lidx[s]),
      .data_o   (sl_data[s])
    );
  end

  // Stage A: per-slice results captured in the request cycle (R8 old contents)
  logic                         a_vld;
  logic                         a_region;
  logic [NSLICE-1:0]            a_en;
  logic [NSLICE-1:0]            a_hit;
  logic [NSLICE-1:0][LW-1:0]    a_lidx;
  logic [NSLICE-1:0][ID_W-1:0]  a_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld    <= 1'b0;
      a_region <= 1'b0;
      a_en     <= '0;
      a_hit    <= '0;
      a_lidx   <= '0;
      a_data   <= '0;
    end else begin
      a_vld <= lk_req;
      if (lk_req) begin
        a_region <= lk_region;
        a_en     <= sl_en;
        a_hit    <= sl_hit;
        a_lidx   <= sl_lidx;
        a_data   <= sl_data;
      end
    end
  end

  trm_resolve #(.NSLICE(NSLICE), .LW(LW), .DATA_W(ID_W), .DEF_INST(DEF_INST)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_vld    (a_vld),
    .a_region (a_region),
    .a_hit    (a_hit),
    .a_lidx   (a_lidx),
    .a_data   (a_data),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_index (rs_index),
    .rs_data  (rs_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_ack <= 1'b0;
    else        cfg_ack <= cfg_we;
  end

  p_req_to_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> a_vld);

  p_stage_to_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld |=> rs_valid);

  p_no_spurious_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !a_vld |=> !rs_valid);

  p_ack_follows_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_ack);

  p_no_spurious_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> !cfg_ack);

  p_hit_only_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld |-> ((a_hit & ~a_en) == '0));

endmodule

// File: tb/sim_sliced_rule_matcher.sv
module sim_sliced_rule_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_kind = 1'b0, cfg_flag = 1'b0, cfg_region = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [71:0] cfg_value = '0, cfg_mask = '0;
  logic [7:0]  cfg_data = '0;
  logic        cfg_ack;
  logic        lk_req = 1'b0, lk_region = 1'b0;
  logic [7:0]  lk_inst = '0;
  logic [63:0] lk_key = '0;
  logic        rs_valid, rs_hit;
  logic [5:0]  rs_index;
  logic [7:0]  rs_data;

  int checks = 0;
  int failures = 0;
  bit reported = 0;

  localparam logic [7:0]  DEF = 8'hFE;
  localparam logic [71:0] ALL = {72{1'b1}};

  always #10 clk = ~clk;

  sliced_rule_matcher u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_addr(cfg_addr),
    .cfg_value(cfg_value), .cfg_mask(cfg_mask), .cfg_data(cfg_data), .cfg_flag(cfg_flag),
    .cfg_region(cfg_region), .cfg_ack(cfg_ack), .lk_req(lk_req), .lk_region(lk_region),
    .lk_inst(lk_inst), .lk_key(lk_key), .rs_valid(rs_valid), .rs_hit(rs_hit),
    .rs_index(rs_index), .rs_data(rs_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wr_entry(input int addr, input logic [71:0] v, input logic [71:0] m,
                          input logic [7:0] d, input logic vld);
    @(negedge clk);
    cfg_we = 1; cfg_kind = 0; cfg_addr = 6'(addr); cfg_value = v; cfg_mask = m;
    cfg_data = d; cfg_flag = vld;
    @(negedge clk);
    cfg_we = 0;
    chk(cfg_ack == 1'b1, "R8 ack after entry write", 72'(cfg_ack), 72'd1);
  endtask

  task automatic wr_slice(input int sl, input logic used, input logic rgn, input logic [7:0] owner);
    @(negedge clk);
    cfg_we = 1; cfg_kind = 1; cfg_addr = 6'(sl * 8); cfg_flag = used; cfg_region = rgn;
    cfg_data = owner;
    @(negedge clk);
    cfg_we = 0;
    chk(cfg_ack == 1'b1, "R8 ack after slice write", 72'(cfg_ack), 72'd1);
  endtask

  task automatic look(input logic rgn, input logic [7:0] inst, input logic [63:0] key,
                      input logic eh, input int ei, input logic [7:0] ed, input string tag);
    @(negedge clk);
    lk_req = 1; lk_region = rgn; lk_inst = inst; lk_key = key;
    @(negedge clk);
    lk_req = 0;
    chk(rs_valid == 1'b0, {tag, " R7 not yet valid"}, 72'(rs_valid), 72'd0);
    @(negedge clk);
    chk(rs_valid == 1'b1, {tag, " R7 valid"}, 72'(rs_valid), 72'd1);
    chk(rs_hit == eh, {tag, " hit"}, 72'(rs_hit), 72'(eh));
    chk(rs_index == 6'(ei), {tag, " index"}, 72'(rs_index), 72'(ei));
    chk(rs_data == ed, {tag, " data"}, 72'(rs_data), 72'(ed));
  endtask

  task automatic t_reset();
    chk(rs_valid == 0, "R9 rs_valid after reset", 72'(rs_valid), 72'd0);
    chk(cfg_ack == 0, "R9 cfg_ack after reset", 72'(cfg_ack), 72'd0);
    look(0, 8'd0, 64'h0, 0, 0, DEF, "R9 map miss after reset");
    look(1, 8'd0, 64'h0, 0, 0, 8'd0, "R9 action miss after reset");
  endtask

  task automatic t_setup();
    wr_slice(0, 1, 0, 8'd0);
    wr_slice(2, 1, 1, 8'd3);
    wr_slice(3, 1, 1, 8'd4);
    wr_entry(0, {8'h0, 64'h0A00_0000_0000_0000}, {8'h0, 64'hFFFF_0000_0000_0000}, 8'd3, 1);
    wr_entry(2, {8'h0, 64'h1234}, ALL, 8'd4, 1);
    wr_entry(3, '0, '0, 8'd6, 0);
    wr_entry(16, {8'd3, 64'h55}, {8'hFF, 64'hFF}, 8'd0, 1);
    wr_entry(17, {8'd4, 64'h0}, {8'hFF, 64'h0}, 8'd0, 1);
    wr_entry(18, {8'h0, 64'h77}, {8'h00, 64'hFF}, 8'd0, 1);
    wr_entry(24, {8'd4, 64'h0}, {8'hFF, 64'h0}, 8'd0, 1);
    wr_entry(25, '0, '0, 8'd0, 1);
  endtask

  task automatic t_ternary();
    look(0, 8'd0, 64'h0A00_FFFF_FFFF_FFFF, 1, 0, 8'd3, "R1 don't-care bits ignored");
    look(0, 8'd0, 64'h1234, 1, 2, 8'd4, "R1 exact match R5 zero id field");
    look(0, 8'd0, 64'h0C00_0000_0000_0000, 0, 0, DEF, "R4 R10 R6 map miss");
  endtask

  task automatic t_action();
    look(1, 8'd3, 64'h55, 1, 16, 8'd0, "R3 own slice hit");
    look(1, 8'd3, 64'h99, 0, 0, 8'd0, "R5 R6 id field mismatch miss");
    look(1, 8'd3, 64'h77, 1, 18, 8'd0, "R5 id field masked");
    look(1, 8'd4, 64'h55, 1, 24, 8'd0, "R3 other tenant slice off");
    look(1, 8'd9, 64'h0, 0, 0, 8'd0, "R3 no owned slice");
  endtask

  task automatic t_priority();
    wr_slice(1, 1, 0, 8'd0);
    wr_entry(9, '0, '0, 8'd7, 1);
    look(0, 8'd0, 64'h0B00_0000_0000_0000, 1, 9, 8'd7, "R2 catch-all hit");
    look(0, 8'd0, 64'h1234, 1, 2, 8'd4, "R2 lower address wins");
    look(0, 8'd0, 64'h0A00_0000_0000_1234, 1, 0, 8'd3, "R2 entry 0 wins");
  endtask

  task automatic t_release();
    wr_slice(3, 0, 1, 8'd4);
    look(1, 8'd4, 64'h55, 0, 0, 8'd0, "R12 released slice ignored");
  endtask

  task automatic t_migrate();
    wr_entry(16, '0, '0, 8'd0, 1);
    look(1, 8'd3, 64'h99, 1, 16, 8'd0, "R11 first rule catch-all");
    look(1, 8'd3, 64'h77, 1, 16, 8'd0, "R11 shadows later rule");
  endtask

  task automatic t_inflight();
    @(negedge clk);
    cfg_we = 1; cfg_kind = 0; cfg_addr = 6'd2; cfg_value = '0; cfg_mask = '0;
    cfg_data = 8'd0; cfg_flag = 0;
    lk_req = 1; lk_region = 0; lk_inst = 0; lk_key = 64'h1234;
    @(negedge clk);
    cfg_we = 0; lk_req = 0;
    chk(cfg_ack == 1, "R8 ack in-flight", 72'(cfg_ack), 72'd1);
    @(negedge clk);
    chk(rs_valid == 1 && rs_index == 6'd2 && rs_data == 8'd4, "R8 in-flight sees old",
        72'({rs_valid, rs_index, rs_data}), 72'({1'b1, 6'd2, 8'd4}));
    look(0, 8'd0, 64'h1234, 1, 9, 8'd7, "R8 after ack sees new");
  endtask

  task automatic t_b2b();
    @(negedge clk);
    lk_req = 1; lk_region = 0; lk_key = 64'h0A00_0000_0000_0000;
    @(negedge clk);
    lk_key = 64'h0B00_0000_0000_0000;
    chk(rs_valid == 0, "R7 b2b first not early", 72'(rs_valid), 72'd0);
    @(negedge clk);
    lk_req = 0;
    chk(rs_valid && rs_index == 6'd0 && rs_data == 8'd3, "R7 b2b first result",
        72'({rs_valid, rs_index, rs_data}), 72'({1'b1, 6'd0, 8'd3}));
    @(negedge clk);
    chk(rs_valid && rs_index == 6'd9 && rs_data == 8'd7, "R7 b2b second result",
        72'({rs_valid, rs_index, rs_data}), 72'({1'b1, 6'd9, 8'd7}));
    @(negedge clk);
    chk(rs_valid == 0, "R7 single result per request", 72'(rs_valid), 72'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_ternary();
    t_action();
    t_priority();
    t_release();
    t_migrate();
    t_inflight();
    t_b2b();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 72'd1, 72'd0);
    report();
  end

endmodule